// File: doc/BRIEF.md
# Serial Control Register Port

This block is a four-wire serial control slave that owns a bank of seventeen 8-bit configuration registers. A host lowers the active-low latch line, clocks in a 24-bit frame most-significant bit first, and raises the latch again. The first byte holds a fixed chip identifier with a read/write flag in its lowest bit. The second byte selects a register. The third byte carries write data, or, on a read, the time slot in which the block shifts the selected register back out on its serial output. The serial clock is fully asynchronous to the system clock. All four serial pins pass through synchronizers, and edges of the serial clock and latch are detected in the system clock domain.

The register contents are exposed as one flat vector for the rest of the chip to decode. On reset, the volume registers (6 to 13) load full scale (0xFF) and every other register loads zero. If all four serial pads sit low while reset is held, the block comes up in standalone mode. In that mode the master-clock-enable bit is forced on and the serial port is ignored. There is no streaming data path here: every pin is a plain level, and no valid/ready handshake applies.

Top module: `spi_cfg_port`

## Requirements
- R1: A frame of exactly 24 bits is sampled on rising serial clock edges while the latch is low, most significant bit first. Its first byte is 0x08 for a write or 0x09 for a read (chip identifier 0x04 in bits 7:1, read flag in bit 0, 1 = read). Its second byte is the register address and its third byte is the data. On a valid write, the register takes the data after the latch rises.
- R2: After a normal reset, registers 6 through 13 read 0xFF, every other register reads 0x00, and the standalone flag is 0.
- R3: A frame whose bits 7:1 of the first byte differ from 0x04 changes no register. On a read, it never enables the serial output.
- R4: A frame addressing register 14, or any address above 16, changes no register. A read of such an address drives eight zero bits with the output enabled.
- R5: A frame that ends with any bit count other than 24 (for example 23 or 25) changes no register.
- R6: On a matching read, the output enable rises after the falling edge that follows the 16th bit and drops after the falling edge that follows the 24th bit. During bits 17 to 24 the addressed register is presented MSB first, and each new bit appears after a falling edge.
- R7: A read frame leaves every register unchanged.
- R8: If the latch, serial clock, data input and serial output pad are all low during reset, the standalone flag is 1 after reset. Register 0 then reads 0x80 (master clock enable is bit 7), and the others keep their R2 defaults.
- R9: In standalone mode, write frames change no register and read frames never enable the serial output.
- R10: Serial clock edges that occur while the latch is high neither shift data nor count bits. A frame that follows them is decoded normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; the pads are sampled for the standalone strap while it is low |
| sclk_i | input | 1 | Serial clock from the host, idle low |
| latch_n_i | input | 1 | Active-low frame latch |
| mosi_i | input | 1 | Serial data from the host |
| cout_pad_i | input | 1 | Level seen on the serial output pad, used only for the reset strap |
| miso_o | output | 1 | Serial read data |
| miso_oe_o | output | 1 | Output enable for the serial read data pad |
| standalone_o | output | 1 | Standalone mode, captured at reset |
| regs_o | output | 136 | Register contents, register n at bits 8n+7:8n |

## Verification
The assertions check on every cycle that registers change only after the latch has gone high, never while a read is driving, and never in standalone mode. They also check that the read output enable and read data move only while the serial clock is low, and that the standalone flag holds steady between resets. The bench scenarios are the only evidence for the data-dependent results: correct address decode, the defaults loaded by each kind of reset, rejection of short, long and misaddressed frames, and the exact bits shifted out on a read.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int          REG_W      = 8;
  localparam int          NUM_REGS   = 17;
  localparam int          FRAME_BITS = 24;
  localparam int          CNT_W      = 5;
  localparam logic [6:0]  CHIP_ID    = 7'h04;
  localparam int          RSVD_ADDR  = 14;
  localparam int          VOL_FIRST  = 6;
  localparam int          VOL_LAST   = 13;
  localparam logic [REG_W-1:0] VOL_FULL = 8'hFF;
  localparam int          CLKEN_REG  = 0;
  localparam int          CLKEN_BIT  = 7;

  // Legal register address: inside the bank and not the reserved slot.
  function automatic logic addr_ok(input logic [7:0] a, input int n);
    return (int'(a) < n) && (int'(a) != RSVD_ADDR);
  endfunction

  // Value a register takes while reset is held.
  function automatic logic [REG_W-1:0] reset_value(input int idx, input logic standalone);
    logic [REG_W-1:0] v;
    v = (idx >= VOL_FIRST && idx <= VOL_LAST) ? VOL_FULL : '0;
    if (standalone && idx == CLKEN_REG) v[CLKEN_BIT] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    stg[0] <= d;
    for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_cfg_pkg::*;
#(
  parameter int NREGS = NUM_REGS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_s,
  input  logic             latch_n_s,
  input  logic             mosi_s,
  input  logic             enable,
  input  logic [REG_W-1:0] rd_data,
  output logic [7:0]       rd_addr,
  output logic             wr_en,
  output logic [7:0]       wr_addr,
  output logic [REG_W-1:0] wr_data,
  output logic             miso,
  output logic             miso_oe
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(FRAME_BITS - REG_W);

  logic                  sclk_q, latch_q;
  logic                  sclk_rise, sclk_fall, latch_rise, active;
  logic [CNT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-1:0] shreg;
  logic [REG_W-1:0]      tx_q;
  logic                  oe_q;
  logic                  rd_start;

  assign sclk_rise  = sclk_s & ~sclk_q;
  assign sclk_fall  = ~sclk_s & sclk_q;
  assign latch_rise = latch_n_s & ~latch_q;
  assign active     = ~latch_n_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      latch_q <= 1'b1;
    end else begin
      sclk_q  <= sclk_s;
      latch_q <= latch_n_s;
    end
  end

  // Bit counter and shift register run only inside a frame.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (!active) begin
      bit_cnt <= '0;
    end else if (sclk_rise) begin
      shreg <= {shreg[FRAME_BITS-2:0], mosi_s};
      if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  // Header of a read is complete once 16 bits are in.
  assign rd_addr  = shreg[7:0];
  assign rd_start = active && sclk_fall && (bit_cnt == CNT_HDR) && enable &&
                    (shreg[15:9] == CHIP_ID) && shreg[8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_q <= 1'b0;
      tx_q <= '0;
    end else if (rd_start) begin
      oe_q <= 1'b1;
      tx_q <= addr_ok(rd_addr, NREGS) ? rd_data : '0;
    end else if (oe_q && (!active || (sclk_fall && bit_cnt >= CNT_FULL))) begin
      oe_q <= 1'b0;
      tx_q <= '0;
    end else if (oe_q && sclk_fall) begin
      tx_q <= {tx_q[REG_W-2:0], 1'b0};
    end
  end

  assign miso    = tx_q[REG_W-1];
  assign miso_oe = oe_q;

  // Write commits on the latch rising edge of a complete frame.
  assign wr_addr = shreg[15:8];
  assign wr_data = shreg[7:0];
  assign wr_en   = latch_rise && (bit_cnt == CNT_FULL) && enable &&
                   (shreg[23:17] == CHIP_ID) && !shreg[16] &&
                   addr_ok(wr_addr, NREGS);
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_cfg_pkg::*;
#(
  parameter int NREGS = NUM_REGS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   strap_low,
  input  logic                   wr_en,
  input  logic [7:0]             wr_addr,
  input  logic [REG_W-1:0]       wr_data,
  input  logic [7:0]             rd_addr,
  output logic [REG_W-1:0]       rd_data,
  output logic                   standalone,
  output logic [NREGS*REG_W-1:0] regs_flat
);
  logic [REG_W-1:0] regs_q [NREGS];
  logic             standalone_q;

  always_ff @(posedge clk) begin
    if (!rst_n) standalone_q <= strap_low;
  end
  assign standalone = standalone_q;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs_q[g] <= reset_value(g, strap_low);
      else if (wr_en && wr_addr == 8'(g))
        regs_q[g] <= wr_data;
    end
    assign regs_flat[g*REG_W +: REG_W] = regs_q[g];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREGS; i++)
      if (rd_addr == 8'(i)) rd_data = regs_q[i];
  end
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
  import spi_cfg_pkg::*;
#(
  parameter int NREGS       = NUM_REGS,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sclk_i,
  input  logic                   latch_n_i,
  input  logic                   mosi_i,
  input  logic                   cout_pad_i,
  output logic                   miso_o,
  output logic                   miso_oe_o,
  output logic                   standalone_o,
  output logic [NREGS*REG_W-1:0] regs_o
);
  logic [3:0]       pins_s;
  logic             wr_en;
  logic [7:0]       wr_addr, rd_addr;
  logic [REG_W-1:0] wr_data, rd_data;
  logic             standalone;

  spi_pin_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   ({cout_pad_i, mosi_i, latch_n_i, sclk_i}),
    .q   (pins_s)
  );

  spi_frame_rx #(.NREGS(NREGS)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (pins_s[0]),
    .latch_n_s (pins_s[1]),
    .mosi_s    (pins_s[2]),
    .enable    (!standalone),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .miso      (miso_o),
    .miso_oe   (miso_oe_o)
  );

  spi_reg_bank #(.NREGS(NREGS)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_low  (pins_s == 4'b0000),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .standalone (standalone),
    .regs_flat  (regs_o)
  );

  assign standalone_o = standalone;
endmodule

// File: rtl/spi_cfg_chk.sv
module spi_cfg_chk #(
  parameter int RW = 136
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sclk_i,
  input logic          latch_n_i,
  input logic          miso_o,
  input logic          miso_oe_o,
  input logic          standalone_o,
  input logic [RW-1:0] regs_o
);
  // R1
  regs_after_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> latch_n_i);

  // R7
  no_write_during_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe_o |-> $stable(regs_o));

  // R6
  oe_rise_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_oe_o) |-> (!latch_n_i && !sclk_i));

  // R6
  data_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso_o) |-> !sclk_i);

  // R9
  standalone_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standalone_o |-> !miso_oe_o);

  // R9
  standalone_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standalone_o |=> $stable(regs_o));

  // R8
  strap_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(standalone_o));
endmodule

bind spi_cfg_port spi_cfg_chk #(.RW(NREGS * spi_cfg_pkg::REG_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sclk_i       (sclk_i),
  .latch_n_i    (latch_n_i),
  .miso_o       (miso_o),
  .miso_oe_o    (miso_oe_o),
  .standalone_o (standalone_o),
  .regs_o       (regs_o)
);

// File: tb/sim_spi_cfg_port.sv
module sim_spi_cfg_port;
  localparam int N    = 17;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, latch_n = 1'b1, mosi = 1'b0, cout_pad = 1'b1;
  logic miso, oe, standalone;
  logic [N*8-1:0] regs;

  int vectors = 0, fails = 0;
  bit done = 0;
  logic [7:0] mdl [N];
  bit mdl_sa = 0;

  always #2 clk = ~clk;

  spi_cfg_port u0 (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .latch_n_i(latch_n), .mosi_i(mosi),
    .cout_pad_i(cout_pad), .miso_o(miso), .miso_oe_o(oe),
    .standalone_o(standalone), .regs_o(regs)
  );

  task automatic wait_clk(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [N*8-1:0] act, input logic [N*8-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit valid_addr(input logic [7:0] a);
    return (a < 8'd17) && (a != 8'd14);
  endfunction

  function automatic logic [7:0] dflt(input int i, input bit sa);
    logic [7:0] v;
    v = (i >= 6 && i <= 13) ? 8'hFF : 8'h00;
    if (sa && i == 0) v = v | 8'h80;
    return v;
  endfunction

  function automatic logic [N*8-1:0] mdl_flat();
    logic [N*8-1:0] f;
    for (int i = 0; i < N; i++) f[i*8 +: 8] = mdl[i];
    return f;
  endfunction

  task automatic do_reset(input bit strap);
    rst_n = 0; sclk = 0; mosi = 0;
    latch_n = strap ? 1'b0 : 1'b1;
    cout_pad = strap ? 1'b0 : 1'b1;
    wait_clk(8);
    rst_n = 1;
    wait_clk(1);
    latch_n = 1; cout_pad = 1;
    wait_clk(6);
    mdl_sa = strap;
    for (int i = 0; i < N; i++) mdl[i] = dflt(i, strap);
  endtask

  task automatic xfer(input logic [23:0] w, input int n,
                      output logic [7:0] rd, output int oe_hits, output int oe_bad);
    rd = 0; oe_hits = 0; oe_bad = 0;
    latch_n = 0;
    wait_clk(4);
    for (int i = 0; i < n; i++) begin
      mosi = (i < 24) ? w[23-i] : 1'b0;
      wait_clk(HALF);
      if (i >= 16 && i < 24) begin
        rd = {rd[6:0], miso};
        if (oe) oe_hits++;
      end else if (oe) oe_bad++;
      sclk = 1;
      wait_clk(HALF);
      sclk = 0;
    end
    wait_clk(HALF);
    latch_n = 1;
    wait_clk(12);
  endtask

  // Runs one frame, updates the model, checks registers, read data and enable.
  task automatic frame(input string req, input logic [6:0] chip, input bit rd_flag,
                       input logic [7:0] addr, input logic [7:0] data, input int n);
    logic [7:0] got, exp_rd;
    int hits, bad;
    bit match;
    match = (chip == 7'h04) && !mdl_sa;
    exp_rd = (rd_flag && match && valid_addr(addr)) ? mdl[addr] : 8'h00;
    xfer({chip, rd_flag, addr, data}, n, got, hits, bad);
    if (!rd_flag && match && n == 24 && valid_addr(addr)) mdl[addr] = data;
    check(req, regs, mdl_flat());
    check(req, oe, 1'b0);
    check(req, bad, 0);
    if (n == 24) begin
      check(req, hits, (rd_flag && match) ? 8 : 0);
      if (rd_flag) check(req, got, exp_rd);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    do_reset(0);
    // R2 reset state
    check("R2", regs, mdl_flat());
    check("R2", standalone, 1'b0);
    check("R2", oe, 1'b0);

    frame("R1", 7'h04, 0, 8'd3, 8'h5A, 24);
    frame("R6", 7'h04, 1, 8'd3, 8'h00, 24);
    frame("R7", 7'h04, 1, 8'd9, 8'h33, 24);
    frame("R1", 7'h04, 0, 8'd16, 8'hC3, 24);
    frame("R6", 7'h04, 1, 8'd16, 8'h00, 24);
    frame("R4", 7'h04, 0, 8'd14, 8'hAA, 24);
    frame("R4", 7'h04, 1, 8'd14, 8'h00, 24);
    frame("R4", 7'h04, 0, 8'd20, 8'h77, 24);
    frame("R4", 7'h04, 1, 8'd200, 8'h00, 24);
    frame("R3", 7'h05, 0, 8'd2, 8'h11, 24);
    frame("R3", 7'h44, 1, 8'd6, 8'h00, 24);
    frame("R5", 7'h04, 0, 8'd2, 8'h22, 23);
    frame("R5", 7'h04, 0, 8'd2, 8'h22, 25);

    // R10: clock edges with latch high are ignored
    for (int k = 0; k < 5; k++) begin
      mosi = 1; sclk = 1; wait_clk(HALF); sclk = 0; wait_clk(HALF);
    end
    frame("R10", 7'h04, 0, 8'd1, 8'h96, 24);
    frame("R10", 7'h04, 1, 8'd1, 8'h00, 24);

    for (int k = 0; k < 120; k++) begin
      logic [6:0] c;
      logic [7:0] a, d;
      bit r;
      c = ($urandom % 6 == 0) ? 7'($urandom) : 7'h04;
      a = 8'($urandom % 21);
      d = 8'($urandom);
      r = 1'($urandom);
      frame(r ? "R6" : "R1", c, r, a, d, 24);
    end

    // R8 standalone strap
    do_reset(1);
    check("R8", standalone, 1'b1);
    check("R8", regs, mdl_flat());
    check("R8", regs[7:0], 8'h80);
    frame("R9", 7'h04, 0, 8'd5, 8'hEE, 24);
    frame("R9", 7'h04, 1, 8'd0, 8'h00, 24);

    do_reset(0);
    check("R2", standalone, 1'b0);
    check("R2", regs, mdl_flat());

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule